// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a simple single-word host port and an asynchronous 64K x 4 dynamic memory whose sixteen address bits share eight pins. A host request carries a direction flag, a 16-bit word address and a 4-bit write word. The controller sends the upper address byte as the row on the falling edge of the row strobe, waits the row hold and row-to-column delays, then sends the lower byte as the column on the falling edge of the column strobe. It leaves the row open afterwards. A later request to the same row needs only a new column strobe pulse. A request to a different row first closes the page and precharges.

An internal interval counter raises a refresh demand at a fixed period in clocks. When a demand is pending, the controller finishes or closes what is open, precharges, and pulses only the row strobe with an 8-bit refresh row on the pins. That row counter steps through all 256 rows in order. Writes lower the write strobe before the column strobe falls, so the memory keeps its outputs off for the whole write cycle while the controller drives the data pins. Every strobe width and gap is a parameter counted in clocks and is enforced as a minimum.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and right after reset, all three strobes (`mem_ras_n`, `mem_cas_n`, `mem_we_n`) are high, `mem_dq_oe` is low, `host_rvalid` is low and `host_ready` is high.
- R2: Each accepted request is served in acceptance order. `mem_addr` equals `host_addr[15:8]` when `mem_ras_n` falls and holds that value for at least `T_RAH` cycles. It equals `host_addr[7:0]` when `mem_cas_n` falls. At that point `mem_we_n` is low for a write and high for a read.
- R3: `mem_ras_n` stays low for at least `T_RAS` cycles each time and stays high for at least `T_RP` cycles between low periods.
- R4: `mem_cas_n` falls only while `mem_ras_n` is low, and no earlier than `T_RCD` cycles after `mem_ras_n` fell. It stays low for at least `T_CAS` cycles. Between two column pulses in one row it stays high for at least `T_CP` cycles.
- R5: A read returns the word sampled from `mem_dq_i` at the end of the column-low period on `host_rdata`. `host_rvalid` is then high for exactly one cycle. The word equals the last value written to that address.
- R6: For a write, `mem_we_n` is already low in the cycle before `mem_cas_n` falls, and `mem_dq_oe` is high with the write word on `mem_dq_o` when `mem_cas_n` falls. `mem_dq_oe` is never high while `mem_cas_n` is low and `mem_we_n` is high.
- R7: A request whose row equals the open row is served with a column pulse alone, with no new `mem_ras_n` fall.
- R8: A request to a row other than the open row raises `mem_ras_n`, waits the precharge time and opens the new row. It costs exactly one extra `mem_ras_n` fall.
- R9: A refresh is a `mem_ras_n` low period with no `mem_cas_n` fall. The refresh rows start at 0 and rise by one modulo 256. Consecutive refreshes start no more than `REF_INTERVAL` plus one worst-case access and close apart, even under continuous host traffic.
- R10: A pending refresh wins over a new host request. `host_ready` is low whenever `mem_cas_n` is low and for the whole of a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request strobe, taken when `host_ready` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address, row in the upper byte |
| host_wdata | input | 4 | Write word |
| host_ready | output | 1 | Controller can take a request this cycle |
| host_rdata | output | 4 | Read word |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | 8 | Multiplexed row/column address |
| mem_dq_o | output | 4 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables `mem_dq_o` onto the shared data pins |
| mem_dq_i | input | 4 | Data arriving from the memory |

## Verification
The bench models the memory behaviourally. It latches the row on each row-strobe fall and the column on each column-strobe fall, so a controller that switched the address pins too early, or sent the halves swapped, would store words at wrong cells, and the read-back comparisons would catch it. Strobe widths and gaps are counted against the minimums. A design that cut precharge short, raised the row strobe before its minimum, or narrowed a column pulse would trip those counts. Long same-row bursts and alternating-row accesses count row-strobe falls, which exposes a page that is reopened needlessly or never closed. Streams of traffic that span several refresh periods, plus an idle stretch past 256 refreshes, show whether refresh is starved by host requests and whether the row counter wraps in order.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRECHG,
        ST_ROW_HOLD,
        ST_COL_SET,
        ST_CAS_LO,
        ST_CAS_HI,
        ST_PAGE,
        ST_CLOSE,
        ST_REF_LO
    } seq_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_refresh_sched.sv
module fpm_refresh_sched #(
    parameter int REF_INTERVAL = 1560,
    parameter int ROW_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pend,
    output logic [ROW_W-1:0] row
);
    localparam int IV_W = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

    typedef struct packed {
        logic [IV_W-1:0]  tick_cnt;
        logic             pend;
        logic [ROW_W-1:0] row;
    } sched_t;

    sched_t q, d;
    logic   tick;

    always_comb begin
        d    = q;
        tick = (q.tick_cnt == IV_W'(REF_INTERVAL - 1));
        if (tick) d.tick_cnt = '0;
        else      d.tick_cnt = q.tick_cnt + IV_W'(1);
        d.pend = (q.pend & ~ack) | tick;
        if (ack) d.row = q.row + ROW_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
    assign row  = q.row;
endmodule

// File: rtl/fpm_ras_window.sv
module fpm_ras_window #(
    parameter int T_RAS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    output logic tras_met
);
    localparam int W_W = $clog2(T_RAS + 1);

    logic [W_W-1:0] lo_cnt_q, lo_cnt_d;

    always_comb begin
        if (ras_n)                          lo_cnt_d = '0;
        else if (lo_cnt_q == W_W'(T_RAS))   lo_cnt_d = lo_cnt_q;
        else                                lo_cnt_d = lo_cnt_q + W_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lo_cnt_q <= '0;
        else        lo_cnt_q <= lo_cnt_d;
    end

    // A rise decided now becomes visible at the next edge: T_RAS-1 elapsed suffices.
    assign tras_met = !ras_n && (32'(lo_cnt_q) >= T_RAS - 1);
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 8,
    parameter int DATA_W = 4,
    parameter int T_RAS  = 5,
    parameter int T_RP   = 4,
    parameter int T_RCD  = 3,
    parameter int T_RAH  = 1,
    parameter int T_CAS  = 2,
    parameter int T_CP   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              ref_pend,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ref_ack,
    input  logic              tras_met,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [ROW_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int COL_W = ADDR_W - ROW_W;
    localparam int TMAX  = max2(max2(max2(T_RAS, T_RP), max2(T_RCD, T_CAS)), T_CP);
    localparam int CNT_W = $clog2(TMAX + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              pend;
        logic [ROW_W-1:0]  rrow;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [ROW_W-1:0]  addr;
        logic              dq_oe;
        logic [DATA_W-1:0] dq_o;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_t;

    seq_t q, d;
    logic cnt_done;
    logic row_hit;

    assign cnt_done   = (q.cnt == '0);
    assign row_hit    = (host_addr[ADDR_W-1:COL_W] == q.row);
    assign host_ready = ((q.state == ST_IDLE) || (q.state == ST_PAGE)) && !ref_pend && !q.pend;

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        ref_ack  = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                if (ref_pend) begin
                    d.state = ST_REF_LO;
                    d.cnt   = CNT_W'(T_RAS - 1);
                    d.rrow  = ref_row;
                    ref_ack = 1'b1;
                end else if (q.pend) begin
                    d.state = ST_ROW_HOLD;
                    d.cnt   = CNT_W'(T_RAH - 1);
                    d.pend  = 1'b0;
                end else if (host_req) begin
                    d.row   = host_addr[ADDR_W-1:COL_W];
                    d.col   = host_addr[COL_W-1:0];
                    d.wr    = host_we;
                    d.wdata = host_wdata;
                    d.state = ST_ROW_HOLD;
                    d.cnt   = CNT_W'(T_RAH - 1);
                end
            end
            ST_PRECHG: begin
                if (cnt_done) d.state = ST_IDLE;
                else          d.cnt   = q.cnt - CNT_W'(1);
            end
            ST_ROW_HOLD: begin
                if (cnt_done) begin
                    d.state = ST_COL_SET;
                    d.cnt   = CNT_W'(T_RCD - T_RAH - 1);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_COL_SET: begin
                if (cnt_done) begin
                    d.state = ST_CAS_LO;
                    d.cnt   = CNT_W'(T_CAS - 1);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_CAS_LO: begin
                if (cnt_done) begin
                    d.state = ST_CAS_HI;
                    d.cnt   = CNT_W'(T_CP - 1);
                    if (!q.wr) begin
                        d.rdata  = mem_dq_i;
                        d.rvalid = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_CAS_HI: begin
                if (cnt_done) d.state = ST_PAGE;
                else          d.cnt   = q.cnt - CNT_W'(1);
            end
            ST_PAGE: begin
                if (ref_pend) begin
                    d.state = ST_CLOSE;
                end else if (host_req) begin
                    d.col   = host_addr[COL_W-1:0];
                    d.wr    = host_we;
                    d.wdata = host_wdata;
                    if (row_hit) begin
                        d.state = ST_COL_SET;
                        d.cnt   = '0;
                    end else begin
                        d.row   = host_addr[ADDR_W-1:COL_W];
                        d.pend  = 1'b1;
                        d.state = ST_CLOSE;
                    end
                end
            end
            ST_CLOSE: begin
                if (tras_met) begin
                    d.state = ST_PRECHG;
                    d.cnt   = CNT_W'(T_RP - 1);
                end
            end
            ST_REF_LO: begin
                if (cnt_done) begin
                    d.state = ST_PRECHG;
                    d.cnt   = CNT_W'(T_RP - 1);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase

        // Pin values follow the state being entered, so every pin leaves a register.
        d.ras_n = (d.state == ST_IDLE) || (d.state == ST_PRECHG);
        d.cas_n = (d.state != ST_CAS_LO);
        d.dq_oe = d.wr && ((d.state == ST_COL_SET) || (d.state == ST_CAS_LO));
        d.we_n  = !d.dq_oe;
        d.dq_o  = d.wdata;
        unique case (d.state)
            ST_ROW_HOLD:          d.addr = d.row;
            ST_COL_SET, ST_CAS_LO: d.addr = ROW_W'(d.col);
            ST_REF_LO:            d.addr = d.rrow;
            default:              d.addr = q.addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mem_ras_n   = q.ras_n;
    assign mem_cas_n   = q.cas_n;
    assign mem_we_n    = q.we_n;
    assign mem_addr    = q.addr;
    assign mem_dq_o    = q.dq_o;
    assign mem_dq_oe   = q.dq_oe;
    assign host_rdata  = q.rdata;
    assign host_rvalid = q.rvalid;
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
    parameter int ADDR_W       = 16,
    parameter int ROW_W        = 8,
    parameter int DATA_W       = 4,
    parameter int T_RAS        = 5,
    parameter int T_RP         = 4,
    parameter int T_RCD        = 3,
    parameter int T_RAH        = 1,
    parameter int T_CAS        = 2,
    parameter int T_CP         = 1,
    parameter int REF_INTERVAL = 1560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [ROW_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    logic             ref_pend;
    logic             ref_ack;
    logic [ROW_W-1:0] ref_row;
    logic             tras_met;

    fpm_refresh_sched #(
        .REF_INTERVAL(REF_INTERVAL),
        .ROW_W       (ROW_W)
    ) u_sched (
        .clk  (clk),
        .rst_n(rst_n),
        .ack  (ref_ack),
        .pend (ref_pend),
        .row  (ref_row)
    );

    fpm_ras_window #(
        .T_RAS(T_RAS)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .ras_n   (mem_ras_n),
        .tras_met(tras_met)
    );

    fpm_seq #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W),
        .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD),
        .T_RAH(T_RAH), .T_CAS(T_CAS), .T_CP(T_CP)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid),
        .ref_pend   (ref_pend),
        .ref_row    (ref_row),
        .ref_ack    (ref_ack),
        .tras_met   (tras_met),
        .mem_ras_n  (mem_ras_n),
        .mem_cas_n  (mem_cas_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_i   (mem_dq_i)
    );
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
    parameter int T_RAS = 5
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dq_oe,
    input logic ready,
    input logic rvalid
);
    localparam int C_W = $clog2(T_RAS + 1);

    logic [C_W-1:0] lo_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                       lo_seen_q <= '0;
        else if (ras_n)                   lo_seen_q <= '0;
        else if (lo_seen_q != C_W'(T_RAS)) lo_seen_q <= lo_seen_q + C_W'(1);
    end

    p_ras_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (32'(lo_seen_q) >= T_RAS));

    p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    p_rvalid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    p_we_before_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> ($past(we_n) == 1'b0));

    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && we_n) |-> !dq_oe);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ready);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RAS(T_RAS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ras_n (mem_ras_n),
    .cas_n (mem_cas_n),
    .we_n  (mem_we_n),
    .dq_oe (mem_dq_oe),
    .ready (host_ready),
    .rvalid(host_rvalid)
);

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int T_RAS = 5, T_RP = 3, T_RCD = 3, T_RAH = 2, T_CAS = 2, T_CP = 2;
    localparam int REF   = 400;
    localparam int SLACK = T_RAS + T_RP + T_RCD + T_RAH + T_CAS + T_CP + 8;
    localparam int WD_CYCLES = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [3:0]  host_rdata;
    logic        mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_addr;
    logic [3:0]  mem_dq_o;
    logic [3:0]  dram_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_dram_ctrl #(
        .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_RAH(T_RAH),
        .T_CAS(T_CAS), .T_CP(T_CP), .REF_INTERVAL(REF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(dram_q)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // host-level reference
    logic [3:0]  shadow [int];
    logic [3:0]  cells  [int];
    logic [16:0] acc_q[$];
    logic [3:0]  rd_q[$];

    // memory-side model state
    int cyc = 0, ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 0, since_fall = 0;
    int ras_falls = 0, ref_cnt = 0, last_ref = 0, fall_cyc = 0;
    bit prev_ras = 1, prev_cas = 1, prev_we = 1, prev_rv = 0;
    bit cas_seen = 0, first_cas = 1, ready_in_ras = 0;
    logic [7:0] row_m = '0, col_m = '0, exp_ref_row = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_ras && !mem_ras_n) begin
                chk(ras_hi >= T_RP, "R3 precharge", ras_hi, T_RP);
                row_m = mem_addr; since_fall = 0; ras_lo = 0; cas_seen = 0;
                first_cas = 1; ready_in_ras = 0; ras_falls++; fall_cyc = cyc;
            end
            if (!prev_ras && mem_ras_n) begin
                chk(ras_lo >= T_RAS, "R3 ras width", ras_lo, T_RAS);
                if (!cas_seen) begin
                    chk(row_m == exp_ref_row, "R9 refresh row", row_m, exp_ref_row);
                    chk(fall_cyc - last_ref <= REF + SLACK, "R9 refresh gap", fall_cyc - last_ref, REF + SLACK);
                    chk(!ready_in_ras, "R10 ready in refresh", ready_in_ras, 0);
                    exp_ref_row = exp_ref_row + 8'd1;
                    last_ref = fall_cyc;
                    ref_cnt++;
                end
                ras_hi = 0;
            end
            if (!mem_ras_n) begin
                ras_lo++;
                if (since_fall < T_RAH)
                    chk(mem_addr == row_m, "R2 row hold", mem_addr, row_m);
                if (host_ready) ready_in_ras = 1;
            end else begin
                ras_hi++;
            end

            if (prev_cas && !mem_cas_n) begin
                chk(!mem_ras_n, "R4 cas outside ras", mem_ras_n, 0);
                chk(since_fall >= T_RCD, "R4 rcd", since_fall, T_RCD);
                if (!first_cas) chk(cas_hi >= T_CP, "R4 cas precharge", cas_hi, T_CP);
                first_cas = 0; cas_seen = 1; col_m = mem_addr; cas_lo = 0;
                if (acc_q.size() == 0) begin
                    chk(0, "R2 unexpected access", {row_m, col_m}, 0);
                end else begin
                    logic [16:0] e;
                    e = acc_q.pop_front();
                    chk({row_m, col_m} == e[15:0], "R2 address", {row_m, col_m}, e[15:0]);
                    chk(mem_we_n == !e[16], "R2 direction", mem_we_n, !e[16]);
                end
                if (!mem_we_n) begin
                    chk(!prev_we && mem_dq_oe, "R6 early write", {prev_we, mem_dq_oe}, 1);
                    cells[{row_m, col_m}] = mem_dq_o;
                end else begin
                    dram_q = cells.exists({row_m, col_m}) ? cells[{row_m, col_m}] : 4'h0;
                end
            end
            if (!prev_cas && mem_cas_n) begin
                chk(cas_lo >= T_CAS, "R4 cas width", cas_lo, T_CAS);
                cas_hi = 0;
            end
            if (!mem_cas_n) begin
                cas_lo++;
                chk(!host_ready, "R10 ready while cas low", host_ready, 0);
                if (mem_we_n) chk(!mem_dq_oe, "R6 contention", mem_dq_oe, 0);
            end else begin
                cas_hi++;
            end
            if (!mem_ras_n) since_fall++;

            if (host_rvalid) begin
                chk(!prev_rv, "R5 pulse width", prev_rv, 0);
                if (rd_q.size() == 0) chk(0, "R5 unexpected data", host_rdata, 0);
                else begin
                    logic [3:0] e;
                    e = rd_q.pop_front();
                    chk(host_rdata == e, "R5 read data", host_rdata, e);
                end
            end
            prev_ras = mem_ras_n; prev_cas = mem_cas_n;
            prev_we = mem_we_n;   prev_rv = host_rvalid;
        end
    end

    task automatic access(input bit we, input logic [15:0] a, input logic [3:0] dat);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = dat;
        while (!host_ready) @(negedge clk);
        acc_q.push_back({we, a});
        if (we) shadow[a] = dat;
        else    rd_q.push_back(shadow.exists(a) ? shadow[a] : 4'h0);
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic drain();
        while (acc_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_refresh();
        int r0;
        r0 = ref_cnt;
        while (ref_cnt == r0) @(negedge clk);
    endtask

    initial begin
        int f0, c0, r0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ras_n && mem_cas_n && mem_we_n, "R1 strobes in reset", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
        chk(!mem_dq_oe && !host_rvalid, "R1 oe/rvalid in reset", {mem_dq_oe, host_rvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready, "R1 ready after reset", host_ready, 1);
        chk(mem_ras_n && mem_cas_n, "R1 strobes after reset", {mem_ras_n, mem_cas_n}, 3);

        // R7: same-row burst opens the row once
        wait_refresh();
        f0 = ras_falls;
        for (int i = 0; i < 8; i++) access(1'b1, {8'h12, 8'(i * 3)}, 4'(i + 5));
        for (int i = 0; i < 8; i++) access(1'b0, {8'h12, 8'(i * 3)}, 4'h0);
        drain();
        chk(ras_falls - f0 == 1, "R7 page hits", ras_falls - f0, 1);

        // R8: alternating rows reopen each time
        f0 = ras_falls;
        access(1'b1, 16'h3405, 4'h9);
        access(1'b0, 16'h1203, 4'h0);
        access(1'b0, 16'h3405, 4'h0);
        drain();
        chk(ras_falls - f0 == 3, "R8 row misses", ras_falls - f0, 3);

        // R5 R6 R10: mixed traffic across several refresh periods
        c0 = cyc; r0 = ref_cnt;
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            a = {8'($urandom % 4), 8'($urandom % 16)};
            access(1'($urandom % 2), a, 4'($urandom));
        end
        drain();
        chk(ref_cnt - r0 >= (cyc - c0) / REF - 1, "R10 refresh under traffic", ref_cnt - r0, (cyc - c0) / REF - 1);

        // R9: idle long enough for the refresh row to wrap
        repeat (260 * REF) @(negedge clk);
        chk(ref_cnt > 256, "R9 row wrap", ref_cnt, 257);
        access(1'b0, 16'h3405, 4'h0);
        drain();
        chk(acc_q.size() == 0 && rd_q.size() == 0, "R2 all served", acc_q.size() + rd_q.size(), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule